// File: doc/BRIEF.md
# Reset and NMI Vector Sequencer

This block sits in front of an 8-bit processor core that uses a 16-bit address bus. It decides when the core may run. While the active-high reset input is asserted, it keeps the core stalled. Once reset is released, it runs two external read cycles at the top of memory to collect the start address. It then hands that address to the core together with a one-cycle start strobe. A rising edge on the non-maskable interrupt input triggers the same two-read sequence at a second vector pair. This request is always honoured and cannot be masked. The new program counter is presented to the core in the same way.

The sequencer owns the external bus while it fetches. When the core is running, the core's address, write request and write data pass through to the bus. The block also produces the system bus clock by dividing the crystal clock.

Top module: `bootvec_seq`

## Requirements
- R1: While `rst_in` is high, `core_hold` is 1 and `start_pulse` is 0. `core_hold` stays 1 until the fetch that follows reset has completed.
- R2: On the first rising edge of `clk` at which `rst_in` is low, the sequencer enters a fetch. It drives `bus_addr` = 16'hFFFE for CLK_DIV cycles, then 16'hFFFF for CLK_DIV cycles, with `bus_rw` high throughout.
- R3: The byte on `bus_rdata` in the last cycle of the first read becomes `pc_out[15:8]`. The byte in the last cycle of the second read becomes `pc_out[7:0]`. `start_pulse` is high in the cycle that follows the second read, which is cycle 2*CLK_DIV counted from the first fetch cycle as cycle 0.
- R4: `start_pulse` lasts exactly one cycle. In that cycle `core_hold` is still 1. After it, `core_hold` is 0, and `pc_out` keeps its value for as long as the core runs.
- R5: A rising edge on `nmi_in`, passed through a two-flop synchroniser, starts a fetch from 16'hFFFC (high byte) and then 16'hFFFD (low byte), with the same timing as R2 and R3. `core_hold` is 1 during this fetch, and the fetch ends with `start_pulse` and the handler address on `pc_out`.
- R6: If `nmi_in` is held high, it produces exactly one NMI fetch. Another fetch needs `nmi_in` to go low and then high again.
- R7: An NMI edge that arrives while a fetch is in progress is remembered. Its NMI fetch runs after the current sequence has finished.
- R8: Raising `rst_in` during an NMI fetch abandons that fetch. After release, the reset vector is fetched and the pending NMI is discarded.
- R9: While the core runs, `bus_addr` = `core_addr`, `bus_rw` = NOT `core_wr` (0 means write), and `bus_wdata` = `core_wdata`. While `core_hold` is 1, `bus_rw` is 1 whatever the value of `core_wr`.
- R10: `bus_data_oe` is 1 only when `bus_rw` is 0 and `out_dis` is 0.
- R11: `sys_clk_out` is 0 while `rst_in` is high. After release it has period CLK_DIV. Sampled k cycles after the first low-reset edge (k = 0, 1, ...), its value is ((k+1) / (CLK_DIV/2)) mod 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst_in | input | 1 | Active-high reset, synchronous |
| nmi_in | input | 1 | Non-maskable interrupt request, asynchronous |
| out_dis | input | 1 | High forbids driving the data bus |
| core_addr | input | ADDR_W | Address from the core while running |
| core_wr | input | 1 | Write request from the core |
| core_wdata | input | DATA_W | Write data from the core |
| bus_rdata | input | DATA_W | Read data from memory |
| bus_addr | output | ADDR_W | External address bus |
| bus_rw | output | 1 | High = read, low = write |
| bus_wdata | output | DATA_W | Write data to the bus |
| bus_data_oe | output | 1 | Data bus drive enable |
| sys_clk_out | output | 1 | Divided system clock |
| core_hold | output | 1 | Core stalled while high |
| start_pulse | output | 1 | One-cycle start strobe |
| pc_out | output | ADDR_W | Program counter loaded from the vector |

## Verification
On every cycle, the assertions check the following properties: the core is held in reset, the bus stays in read mode while the core is held, the start strobe is a single cycle inside the hold, the program counter stays stable while the core runs, and the data-bus enable is consistent with the read/write line and `out_dis`. Some behaviours can only be shown by the bench's scenarios. These are the vector addresses and their order, the exact cycle of the start strobe, the bytes that land in each half of the program counter, one fetch per held NMI, a deferred NMI after a reset fetch, abort by reset, and the phase of the divided clock.

// File: rtl/vecseq_pkg.sv
package vecseq_pkg;
   typedef enum logic [2:0] {
      SQ_WAIT_RST = 3'd0,
      SQ_READ_HI  = 3'd1,
      SQ_READ_LO  = 3'd2,
      SQ_LAUNCH   = 3'd3,
      SQ_RUN      = 3'd4
   } seq_state_t;
endpackage

// File: rtl/vecseq_clkdiv.sv
module vecseq_clkdiv #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_in,
   output logic sys_clk_out
);
   localparam int HALF = DIV / 2;

   generate
      if (DIV == 2) begin : g_toggle
         always_ff @(posedge clk) begin
            if (rst_in) sys_clk_out <= 1'b0;
            else        sys_clk_out <= ~sys_clk_out;
         end
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst_in) begin
               cnt         <= '0;
               sys_clk_out <= 1'b0;
            end else begin
               cnt <= (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
               if (cnt == CW'(HALF - 1) || cnt == CW'(DIV - 1))
                  sys_clk_out <= ~sys_clk_out;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/vecseq_nmi_edge.sv
module vecseq_nmi_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_in,
   input  logic nmi_in,
   output logic nmi_rise
);
   logic [SYNC_STAGES:0] chain;

   always_ff @(posedge clk) begin
      if (rst_in) chain <= '0;
      else        chain <= {chain[SYNC_STAGES-1:0], nmi_in};
   end

   assign nmi_rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
endmodule

// File: rtl/vecseq_fetch.sv
module vecseq_fetch
   import vecseq_pkg::*;
#(
   parameter int              ADDR_W  = 16,
   parameter int              DATA_W  = 8,
   parameter int              DIV     = 4,
   parameter logic [ADDR_W-1:0] VEC_RST = 16'hFFFE,
   parameter logic [ADDR_W-1:0] VEC_NMI = 16'hFFFC
) (
   input  logic              clk,
   input  logic              rst_in,
   input  logic              nmi_rise,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              fetch_active,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic              core_hold,
   output logic              start_pulse,
   output logic [ADDR_W-1:0] pc_out
);
   localparam int CW = $clog2(DIV);

   seq_state_t        state;
   logic [CW-1:0]     bcnt;
   logic              is_nmi;
   logic              pending;
   logic [DATA_W-1:0] pc_hi, pc_lo;
   logic              last_beat;
   logic [ADDR_W-1:0] base;

   assign last_beat = (bcnt == CW'(DIV - 1));

   always_ff @(posedge clk) begin
      if (rst_in) begin
         state   <= SQ_WAIT_RST;
         bcnt    <= '0;
         is_nmi  <= 1'b0;
         pending <= 1'b0;
         pc_hi   <= '0;
         pc_lo   <= '0;
      end else begin
         if (nmi_rise) pending <= 1'b1;
         unique case (state)
            SQ_WAIT_RST: begin
               state  <= SQ_READ_HI;
               bcnt   <= '0;
               is_nmi <= 1'b0;
            end
            SQ_READ_HI: begin
               if (last_beat) begin
                  pc_hi <= bus_rdata;
                  bcnt  <= '0;
                  state <= SQ_READ_LO;
               end else begin
                  bcnt <= bcnt + 1'b1;
               end
            end
            SQ_READ_LO: begin
               if (last_beat) begin
                  pc_lo <= bus_rdata;
                  bcnt  <= '0;
                  state <= SQ_LAUNCH;
               end else begin
                  bcnt <= bcnt + 1'b1;
               end
            end
            SQ_LAUNCH: state <= SQ_RUN;
            SQ_RUN: begin
               if (pending || nmi_rise) begin
                  state   <= SQ_READ_HI;
                  bcnt    <= '0;
                  is_nmi  <= 1'b1;
                  pending <= 1'b0;
               end
            end
            default: state <= SQ_WAIT_RST;
         endcase
      end
   end

   assign base         = is_nmi ? VEC_NMI : VEC_RST;
   assign fetch_active = (state == SQ_READ_HI) || (state == SQ_READ_LO);
   assign fetch_addr   = (state == SQ_READ_LO) ? base + ADDR_W'(1) : base;
   assign core_hold    = (state != SQ_RUN);
   assign start_pulse  = (state == SQ_LAUNCH);
   assign pc_out       = {pc_hi, pc_lo};
endmodule

// File: rtl/bootvec_seq.sv
module bootvec_seq #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int CLK_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_in,
   input  logic              nmi_in,
   input  logic              out_dis,
   input  logic [ADDR_W-1:0] core_addr,
   input  logic              core_wr,
   input  logic [DATA_W-1:0] core_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rw,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_data_oe,
   output logic              sys_clk_out,
   output logic              core_hold,
   output logic              start_pulse,
   output logic [ADDR_W-1:0] pc_out
);
   localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
   localparam logic [ADDR_W-1:0] VEC_RST  = TOP_ADDR - ADDR_W'(1);
   localparam logic [ADDR_W-1:0] VEC_NMI  = TOP_ADDR - ADDR_W'(3);

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("bootvec_seq: ADDR_W must be twice DATA_W");
      end
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("bootvec_seq: CLK_DIV must be even and at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("bootvec_seq: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              nmi_rise;
   logic              fetch_active;
   logic [ADDR_W-1:0] fetch_addr;

   vecseq_clkdiv #(.DIV(CLK_DIV)) u_div (
      .clk(clk), .rst_in(rst_in), .sys_clk_out(sys_clk_out)
   );

   vecseq_nmi_edge #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
      .clk(clk), .rst_in(rst_in), .nmi_in(nmi_in), .nmi_rise(nmi_rise)
   );

   vecseq_fetch #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV(CLK_DIV),
      .VEC_RST(VEC_RST), .VEC_NMI(VEC_NMI)
   ) u_fetch (
      .clk(clk), .rst_in(rst_in), .nmi_rise(nmi_rise), .bus_rdata(bus_rdata),
      .fetch_active(fetch_active), .fetch_addr(fetch_addr),
      .core_hold(core_hold), .start_pulse(start_pulse), .pc_out(pc_out)
   );

   always_comb begin
      if (fetch_active) begin
         bus_addr = fetch_addr;
         bus_rw   = 1'b1;
      end else if (!core_hold) begin
         bus_addr = core_addr;
         bus_rw   = ~core_wr;
      end else begin
         bus_addr = core_addr;
         bus_rw   = 1'b1;
      end
   end

   assign bus_wdata   = core_wdata;
   assign bus_data_oe = ~bus_rw & ~out_dis;
endmodule

// File: rtl/vecseq_checker.sv
module vecseq_checker #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_in,
   input logic              out_dis,
   input logic              bus_rw,
   input logic              bus_data_oe,
   input logic              sys_clk_out,
   input logic              core_hold,
   input logic              start_pulse,
   input logic [ADDR_W-1:0] pc_out,
   input logic [DATA_W-1:0] bus_rdata
);
   logic rst_q = 1'b0;

   always @(posedge clk) begin
      if (rst_q) begin
         assert_hold_in_reset_R1: assert (core_hold && !start_pulse)
            else $error("core not held after reset edge");
         assert_sysclk_low_reset_R11: assert (!sys_clk_out)
            else $error("system clock not low in reset");
      end
      rst_q <= rst_in;
   end

   assert_read_while_held_R9: assert property (@(posedge clk) disable iff (rst_in)
      core_hold |-> bus_rw);

   assert_start_inside_hold_R3: assert property (@(posedge clk) disable iff (rst_in)
      start_pulse |-> core_hold);

   assert_start_single_R4: assert property (@(posedge clk) disable iff (rst_in)
      start_pulse |=> (!start_pulse && !core_hold));

   assert_pc_stable_run_R4: assert property (@(posedge clk) disable iff (rst_in)
      !core_hold |=> (core_hold || $stable(pc_out)));

   assert_od_blocks_drive_R10: assert property (@(posedge clk) disable iff (rst_in)
      out_dis |-> !bus_data_oe);

   assert_drive_only_write_R10: assert property (@(posedge clk) disable iff (rst_in)
      bus_data_oe |-> !bus_rw);

   logic unused_ok;
   assign unused_ok = ^bus_rdata;
endmodule

bind bootvec_seq vecseq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_in(rst_in), .out_dis(out_dis), .bus_rw(bus_rw),
   .bus_data_oe(bus_data_oe), .sys_clk_out(sys_clk_out), .core_hold(core_hold),
   .start_pulse(start_pulse), .pc_out(pc_out), .bus_rdata(bus_rdata)
);

// File: tb/bootvec_seq_test.sv
`timescale 1ns/1ps
module bootvec_seq_test;
   localparam int DIV  = 4;
   localparam int HALF = DIV / 2;

   logic        clk = 1'b0;
   logic        rst_in = 1'b1;
   logic        nmi_in = 1'b0;
   logic        out_dis = 1'b0;
   logic [15:0] core_addr = 16'h1234;
   logic        core_wr = 1'b0;
   logic [7:0]  core_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic [15:0] bus_addr;
   logic        bus_rw;
   logic [7:0]  bus_wdata;
   logic        bus_data_oe;
   logic        sys_clk_out;
   logic        core_hold;
   logic        start_pulse;
   logic [15:0] pc_out;

   int checks = 0;
   int errors = 0;
   int seed   = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   bootvec_seq #(.CLK_DIV(DIV)) uut (
      .clk(clk), .rst_in(rst_in), .nmi_in(nmi_in), .out_dis(out_dis),
      .core_addr(core_addr), .core_wr(core_wr), .core_wdata(core_wdata),
      .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_rw(bus_rw),
      .bus_wdata(bus_wdata), .bus_data_oe(bus_data_oe),
      .sys_clk_out(sys_clk_out), .core_hold(core_hold),
      .start_pulse(start_pulse), .pc_out(pc_out)
   );

   function automatic logic [7:0] mem_byte(input logic [15:0] a, input int s);
      return (a[7:0] * 8'd37 + 8'(s) * 8'd11) ^ 8'h5A;
   endfunction

   function automatic logic [15:0] vec_of(input logic [15:0] a, input int s);
      return {mem_byte(a, s), mem_byte(a + 16'd1, s)};
   endfunction

   always_comb bus_rdata = mem_byte(bus_addr, seed);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_in = 1'b1;
      repeat (3) @(negedge clk);
      check(core_hold === 1'b1 && start_pulse === 1'b0, "R1 hold in reset",
            {core_hold, start_pulse}, 2'b10);
      check(sys_clk_out === 1'b0, "R11 sysclk low in reset", sys_clk_out, 0);
      rst_in = 1'b0;
   endtask

   task automatic run_fetch(input logic [15:0] hi, input logic [15:0] exp_pc, input string req);
      int k;
      bit found = 0;
      for (int w = 0; w < 40 && !found; w++) begin
         @(negedge clk);
         if (bus_addr == hi) found = 1;
      end
      check(found, {req, " vector address seen"}, bus_addr, hi);
      if (found) begin
         check(core_hold === 1'b1 && bus_rw === 1'b1, {req, " R9 hold and read"},
               {core_hold, bus_rw}, 2'b11);
         for (k = 1; k < 2 * DIV; k++) begin
            @(negedge clk);
            if (k < DIV) check(bus_addr == hi, {req, " R2 high-byte address"}, bus_addr, hi);
            else check(bus_addr == hi + 16'd1, {req, " R2 low-byte address"}, bus_addr, hi + 16'd1);
         end
         @(negedge clk);
         check(start_pulse === 1'b1 && core_hold === 1'b1, {req, " R3 start at 2*DIV"},
               {start_pulse, core_hold}, 2'b11);
         check(pc_out == exp_pc, {req, " R3 pc value"}, pc_out, exp_pc);
         @(negedge clk);
         check(start_pulse === 1'b0, {req, " R4 single pulse"}, start_pulse, 0);
      end
   endtask

   initial begin : watchdog
      int cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected done", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R11 divided clock phase after reset release
      do_reset();
      for (int k = 0; k < 3 * DIV; k++) begin
         @(negedge clk);
         check(sys_clk_out === 1'(((k + 1) / HALF) % 2), "R11 sysclk phase",
               sys_clk_out, ((k + 1) / HALF) % 2);
      end

      // R1 R2 R3 R4 reset vector over several memory contents
      for (int s = 0; s < 8; s++) begin
         seed = s;
         do_reset();
         run_fetch(16'hFFFE, vec_of(16'hFFFE, s), "R2 reset fetch");
         check(core_hold === 1'b0, "R4 running after start", core_hold, 0);
         repeat (3) @(negedge clk);
         check(pc_out == vec_of(16'hFFFE, s), "R4 pc stable", pc_out, vec_of(16'hFFFE, s));
      end

      // R9 R10 bus pass-through, all combinations of write and disable
      for (int c = 0; c < 4; c++) begin
         core_wr    = c[0];
         out_dis    = c[1];
         core_addr  = 16'h0100 + 16'(c * 16'h0111);
         core_wdata = 8'(8'hA0 + c);
         @(negedge clk);
         check(bus_addr == core_addr && bus_rw === ~core_wr && bus_wdata == core_wdata,
               "R9 core pass-through", {bus_addr, bus_rw}, {core_addr, ~core_wr});
         check(bus_data_oe === (core_wr & ~out_dis), "R10 data enable",
               bus_data_oe, core_wr & ~out_dis);
      end
      core_wr = 1'b0; out_dis = 1'b0; core_addr = 16'h1234;

      // R9 write request ignored while held
      seed = 3;
      rst_in = 1'b1;
      repeat (2) @(negedge clk);
      rst_in = 1'b0;
      core_wr = 1'b1;
      @(negedge clk);
      check(bus_rw === 1'b1 && bus_addr == 16'hFFFE && bus_data_oe === 1'b0,
            "R9 write ignored in fetch", {bus_rw, bus_addr}, {1'b1, 16'hFFFE});
      core_wr = 1'b0;
      repeat (2 * DIV + 2) @(negedge clk);

      // R5 NMI fetch, R6 held NMI gives one fetch
      for (int s = 1; s < 4; s++) begin
         seed = s;
         nmi_in = 1'b1;
         run_fetch(16'hFFFC, vec_of(16'hFFFC, s), "R5 nmi fetch");
         begin
            int extra = 0;
            for (int w = 0; w < 30; w++) begin
               @(negedge clk);
               if (bus_addr == 16'hFFFC || core_hold) extra++;
            end
            check(extra == 0, "R6 held nmi single fetch", extra, 0);
         end
         nmi_in = 1'b0;
         repeat (4) @(negedge clk);
      end

      // R7 NMI during reset fetch is deferred
      seed = 5;
      do_reset();
      nmi_in = 1'b1;
      run_fetch(16'hFFFE, vec_of(16'hFFFE, 5), "R7 reset before nmi");
      run_fetch(16'hFFFC, vec_of(16'hFFFC, 5), "R7 deferred nmi");
      nmi_in = 1'b0;
      repeat (4) @(negedge clk);

      // R8 reset aborts an NMI fetch
      seed = 6;
      nmi_in = 1'b1;
      begin
         bit seen = 0;
         for (int w = 0; w < 20 && !seen; w++) begin
            @(negedge clk);
            if (bus_addr == 16'hFFFC) seen = 1;
         end
         check(seen, "R8 nmi fetch started", bus_addr, 16'hFFFC);
      end
      nmi_in = 1'b0;
      do_reset();
      run_fetch(16'hFFFE, vec_of(16'hFFFE, 6), "R8 reset after abort");
      begin
         int nmis = 0;
         for (int w = 0; w < 20; w++) begin
            @(negedge clk);
            if (bus_addr == 16'hFFFC) nmis++;
         end
         check(nmis == 0, "R8 aborted nmi discarded", nmis, 0);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule